// File: doc/BRIEF.md
# Converter Command Bus Interface

This block sits between a host's parallel bus and the internal sequencers of a data converter. The host writes configuration words and commands over the bus. Chip select, read and write are all active low. The block holds the configuration register and decodes the command field of each complete write. It starts the calibration, offset-zeroing or conversion sequencer with a one-cycle go pulse, then waits for that sequencer's done signal. It drives an active-low ready output and an active-low standby output that tell the host when it may issue the next command.

The bus runs in one of two widths, chosen by the `mode13` pin. In the narrow mode each write carries one byte. A write lands in the low byte of the configuration register unless the previous low-byte write set the pointer bit, bit 7. When that bit was set, the write lands in the upper field and carries the command. In the wide mode a single write loads the whole register and carries the command at once. A read with chip select low returns the most recent conversion result that the conversion sequencer delivered.

Top module: `cmd_bus_if`

## Requirements
- R1: While reset is asserted and after it is released, the block is in standby: `rdy_n`=1, `stby_n`=0, `cfg_out`=0, no go pulse is issued.
- R2: With `mode13`=0 and the pointer clear, an accepted write loads `din[7:0]` into `cfg_out[7:0]`, leaves `cfg_out[12:8]` unchanged, and sets the pointer to `din[7]`.
- R3: With `mode13`=0 and the pointer set, the next accepted write loads `din[4:0]` into `cfg_out[12:8]` and decodes `din[2:0]` as the command. It then clears the pointer, so the following write targets the low byte again.
- R4: With `mode13`=1, one accepted write loads all 13 bits of `din` into `cfg_out` and decodes `din[10:8]` as the command.
- R5: Command codes are 1 for full calibration and 2 for offset zeroing. The first raises `go_cal` and the second raises `go_az`, in each case for exactly one cycle after the accepting edge. `rdy_n` is 1 from that cycle onward and returns to 0 in the cycle after the matching done input (`cal_done` or `az_done`) is sampled high.
- R6: Command code 4 starts a conversion. It raises `go_conv` for one cycle and holds `rdy_n` at 1. The edge that samples `conv_done` high stores `conv_result` and makes `rdy_n` 0 in the next cycle.
- R7: Command code 5 enters standby: `rdy_n`=1 and `stby_n`=0 from the next cycle.
- R8: From standby, codes 1, 2, 3 and 4 set `stby_n` to 1 in the next cycle. Code 3 also makes `rdy_n` 0 at once, and codes 1, 2 and 4 hold `rdy_n` at 1 until their operation completes.
- R9: Command code 3 resets the configuration register and the pointer to 0 and leaves the block ready.
- R10: A write made while `rdy_n`=1 and `stby_n`=1 has no effect: `cfg_out`, the pointer and the go outputs are unchanged.
- R11: `dout` equals the stored conversion result while `cs_n` and `rd_n` are both 0, and is 0 otherwise.
- R12: A done input that does not match the operation in progress, or that arrives while no operation is in progress, is ignored: `rdy_n`, `stby_n` and the stored result are unchanged.
- R13: Command codes 0, 6 and 7 only store configuration bits; the ready and standby state is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, one write per sampled cycle |
| mode13 | input | 1 | 1 selects the single-write wide mode, 0 the byte mode |
| din | input | 13 | Write data |
| dout | output | 12 | Read data (last conversion result) |
| rdy_n | output | 1 | Active-low ready |
| stby_n | output | 1 | Active-low standby indicator |
| cfg_out | output | 13 | Configuration register contents |
| go_cal | output | 1 | One-cycle start of full calibration |
| go_az | output | 1 | One-cycle start of offset zeroing |
| go_conv | output | 1 | One-cycle start of conversion |
| cal_done | input | 1 | Calibration sequencer finished |
| az_done | input | 1 | Offset-zeroing sequencer finished |
| conv_done | input | 1 | Conversion finished, result valid |
| conv_result | input | 12 | Conversion result from the converter core |

## Verification
A write is taken on the edge that samples `cs_n` and `wr_n` low. `cfg_out`, `rdy_n`, `stby_n` and the go pulses all reflect that write one edge later, through one register stage. A done input moves `rdy_n` low one edge after it is sampled, while `dout` follows `cs_n` and `rd_n` in the same cycle with no register in between. The bench keeps a behavioural model that it advances on each rising edge, using the inputs the bench drove at the falling edge before. It compares every output against that model 2 ns after the edge. The directed checks are timed to these latencies: writes and done pulses span one falling-to-falling window, results are checked 1 ns after the window closes, and reads are checked inside the window that holds the strobes.

// File: rtl/cbi_pkg.sv
package cbi_pkg;

  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_FCAL  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_ZERO  = 3'd2;
  localparam logic [OPC_W-1:0] OPC_RST   = 3'd3;
  localparam logic [OPC_W-1:0] OPC_START = 3'd4;
  localparam logic [OPC_W-1:0] OPC_SLEEP = 3'd5;

  typedef enum logic [2:0] {
    ST_STBY = 3'd0,
    ST_IDLE = 3'd1,
    ST_CAL  = 3'd2,
    ST_AZ   = 3'd3,
    ST_CONV = 3'd4
  } cbi_state_e;

  // A write may be taken only when the block is ready or asleep.
  function automatic logic accepts_write(cbi_state_e st);
    return (st == ST_IDLE) || (st == ST_STBY);
  endfunction

  // Operation in progress, matched against the done inputs.
  function automatic logic op_finished(cbi_state_e st, logic cal_d, logic az_d, logic conv_d);
    return ((st == ST_CAL) && cal_d) || ((st == ST_AZ) && az_d) || ((st == ST_CONV) && conv_d);
  endfunction

endpackage

// File: rtl/cbi_cfg_regs.sv
module cbi_cfg_regs #(
  parameter int DW    = 13,
  parameter int LOW_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_acc,
  input  logic          mode13,
  input  logic [DW-1:0] din,
  input  logic          clr_cfg,
  output logic [DW-1:0] cfg_q,
  output logic          hb_q,
  output logic          up_wr,
  output logic [cbi_pkg::OPC_W-1:0] opcode
);
  localparam int UP_W   = DW - LOW_W;
  localparam int HB_BIT = LOW_W - 1;

  // A write reaches the command field in wide mode or when the pointer is set.
  always_comb begin
    up_wr  = wr_acc && (mode13 || hb_q);
    opcode = mode13 ? din[LOW_W +: cbi_pkg::OPC_W] : din[cbi_pkg::OPC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_cfg) begin
      cfg_q <= '0;
      hb_q  <= 1'b0;
    end else if (wr_acc) begin
      if (mode13) begin
        cfg_q <= din;
        hb_q  <= 1'b0;
      end else if (hb_q) begin
        cfg_q[DW-1:LOW_W] <= din[UP_W-1:0];
        hb_q              <= 1'b0;
      end else begin
        cfg_q[LOW_W-1:0] <= din[LOW_W-1:0];
        hb_q             <= din[HB_BIT];
      end
    end
  end
endmodule

// File: rtl/cbi_ctrl.sv
module cbi_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_req,
  input  logic cmd_valid,
  input  logic [cbi_pkg::OPC_W-1:0] opcode,
  input  logic cal_done,
  input  logic az_done,
  input  logic conv_done,
  output logic wr_acc,
  output logic conv_end,
  output logic go_cal,
  output logic go_az,
  output logic go_conv,
  output logic rdy_n,
  output logic stby_n
);
  import cbi_pkg::*;

  cbi_state_e state_q, state_d;
  logic gc_d, ga_d, gv_d;

  always_comb begin
    wr_acc   = wr_req && accepts_write(state_q);
    conv_end = (state_q == ST_CONV) && conv_done;
    rdy_n    = (state_q != ST_IDLE);
    stby_n   = (state_q != ST_STBY);
  end

  always_comb begin
    state_d = state_q;
    gc_d = 1'b0;
    ga_d = 1'b0;
    gv_d = 1'b0;
    if (op_finished(state_q, cal_done, az_done, conv_done))
      state_d = ST_IDLE;
    if (cmd_valid) begin
      case (opcode)
        OPC_FCAL:  begin state_d = ST_CAL;  gc_d = 1'b1; end
        OPC_ZERO:  begin state_d = ST_AZ;   ga_d = 1'b1; end
        OPC_START: begin state_d = ST_CONV; gv_d = 1'b1; end
        OPC_RST:   state_d = ST_IDLE;
        OPC_SLEEP: state_d = ST_STBY;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_STBY;
      go_cal  <= 1'b0;
      go_az   <= 1'b0;
      go_conv <= 1'b0;
    end else begin
      state_q <= state_d;
      go_cal  <= gc_d;
      go_az   <= ga_d;
      go_conv <= gv_d;
    end
  end
endmodule

// File: rtl/cbi_result.sv
module cbi_result #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [RW-1:0] result_in,
  input  logic          rd_sel,
  output logic [RW-1:0] dout
);
  logic [RW-1:0] res_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       res_q <= '0;
    else if (capture) res_q <= result_in;
  end

  assign dout = rd_sel ? res_q : '0;
endmodule

// File: rtl/cmd_bus_if.sv
module cmd_bus_if #(
  parameter int DATA_W = 13,
  parameter int LOW_W  = 8,
  parameter int RES_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              mode13,
  input  logic [DATA_W-1:0] din,
  output logic [RES_W-1:0]  dout,
  output logic              rdy_n,
  output logic              stby_n,
  output logic [DATA_W-1:0] cfg_out,
  output logic              go_cal,
  output logic              go_az,
  output logic              go_conv,
  input  logic              cal_done,
  input  logic              az_done,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);
  import cbi_pkg::*;

  // Named internal events, watched by the bound checker.
  logic             wr_req;
  logic             rd_sel;
  logic             wr_acc;
  logic             up_wr;
  logic             hb_ptr;
  logic             conv_end;
  logic             clr_cfg;
  logic [OPC_W-1:0] opcode;

  assign wr_req  = !cs_n && !wr_n;
  assign rd_sel  = !cs_n && !rd_n;
  assign clr_cfg = up_wr && (opcode == OPC_RST);

  cbi_cfg_regs #(.DW(DATA_W), .LOW_W(LOW_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_acc  (wr_acc),
    .mode13  (mode13),
    .din     (din),
    .clr_cfg (clr_cfg),
    .cfg_q   (cfg_out),
    .hb_q    (hb_ptr),
    .up_wr   (up_wr),
    .opcode  (opcode)
  );

  cbi_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .cmd_valid (up_wr),
    .opcode    (opcode),
    .cal_done  (cal_done),
    .az_done   (az_done),
    .conv_done (conv_done),
    .wr_acc    (wr_acc),
    .conv_end  (conv_end),
    .go_cal    (go_cal),
    .go_az     (go_az),
    .go_conv   (go_conv),
    .rdy_n     (rdy_n),
    .stby_n    (stby_n)
  );

  cbi_result #(.RW(RES_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (conv_end),
    .result_in (conv_result),
    .rd_sel    (rd_sel),
    .dout      (dout)
  );
endmodule

// File: rtl/cbi_checker.sv
module cbi_checker #(
  parameter int DW = 13,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          rd_n,
  input logic          rdy_n,
  input logic          stby_n,
  input logic          go_cal,
  input logic          go_az,
  input logic          go_conv,
  input logic          wr_acc,
  input logic          hb_ptr,
  input logic          conv_end,
  input logic [DW-1:0] cfg_out,
  input logic [RW-1:0] dout
);
  p_reset_stby_r1: assert property (@(posedge clk) $rose(rst_n) |-> (!stby_n && rdy_n));

  p_hb_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_ptr && wr_acc) |=> !hb_ptr);

  p_go_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({go_cal, go_az, go_conv}));

  p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cal || go_az) |=> !(go_cal || go_az));

  p_busy_on_go_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_cal || go_az || go_conv) |-> (rdy_n && stby_n));

  p_conv_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end |=> !rdy_n);

  p_stby_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stby_n |-> rdy_n);

  p_exit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(stby_n) && rdy_n) |-> (go_cal || go_az || go_conv));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_n && stby_n) |=> $stable(cfg_out));

  p_dout_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (dout == '0));
endmodule

bind cmd_bus_if cbi_checker #(.DW(DATA_W), .RW(RES_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .rdy_n    (rdy_n),
  .stby_n   (stby_n),
  .go_cal   (go_cal),
  .go_az    (go_az),
  .go_conv  (go_conv),
  .wr_acc   (wr_acc),
  .hb_ptr   (hb_ptr),
  .conv_end (conv_end),
  .cfg_out  (cfg_out),
  .dout     (dout)
);

// File: tb/cmd_bus_if_bench.sv
`timescale 1ns/1ps
module cmd_bus_if_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mode13 = 1'b0;
  logic [12:0] din = '0;
  logic [11:0] dout;
  logic        rdy_n, stby_n, go_cal, go_az, go_conv;
  logic [12:0] cfg_out;
  logic        cal_done = 1'b0, az_done = 1'b0, conv_done = 1'b0;
  logic [11:0] conv_result = '0;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done_run = 1'b0;

  always #5 clk = ~clk;

  cmd_bus_if u_cmd_bus_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode13(mode13), .din(din), .dout(dout), .rdy_n(rdy_n), .stby_n(stby_n),
    .cfg_out(cfg_out), .go_cal(go_cal), .go_az(go_az), .go_conv(go_conv),
    .cal_done(cal_done), .az_done(az_done), .conv_done(conv_done),
    .conv_result(conv_result)
  );

  // Behavioural model: 0 asleep, 1 ready, 2 calibrating, 3 zeroing, 4 converting.
  int m_st = 0, m_cfg = 0, m_res = 0, m_gc = 0, m_ga = 0, m_gv = 0;
  bit m_ptr = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int cmd;
    bit wide_or_up;
    m_gc = 0; m_ga = 0; m_gv = 0;
    if (!rst_n) begin
      m_st = 0; m_cfg = 0; m_res = 0; m_ptr = 0;
    end else begin
      cmd = -1;
      if ((m_st == 2 && cal_done) || (m_st == 3 && az_done)) m_st = 1;
      else if (m_st == 4 && conv_done) begin m_st = 1; m_res = int'(conv_result); end
      else if (!cs_n && !wr_n && (m_st == 0 || m_st == 1)) begin
        wide_or_up = mode13 || m_ptr;
        if (mode13) begin
          m_cfg = int'(din); cmd = (int'(din) >> 8) & 7; m_ptr = 0;
        end else if (m_ptr) begin
          m_cfg = (m_cfg & 'hFF) | ((int'(din) & 'h1F) << 8); cmd = int'(din) & 7; m_ptr = 0;
        end else begin
          m_cfg = (m_cfg & 'h1F00) | (int'(din) & 'hFF); m_ptr = din[7];
        end
        if (wide_or_up) begin
          if (cmd == 1) begin m_st = 2; m_gc = 1; end
          else if (cmd == 2) begin m_st = 3; m_ga = 1; end
          else if (cmd == 4) begin m_st = 4; m_gv = 1; end
          else if (cmd == 3) begin m_st = 1; m_cfg = 0; m_ptr = 0; end
          else if (cmd == 5) m_st = 0;
        end
      end
    end
    #2;
    check(cur_req, "rdy_n", int'(rdy_n), (m_st == 1) ? 0 : 1);
    check(cur_req, "stby_n", int'(stby_n), (m_st == 0) ? 0 : 1);
    check(cur_req, "cfg_out", int'(cfg_out), m_cfg);
    check(cur_req, "go", int'({go_cal, go_az, go_conv}), (m_gc << 2) | (m_ga << 1) | m_gv);
    check(cur_req, "dout", int'(dout), (!cs_n && !rd_n) ? m_res : 0);
  end

  task automatic wr(input logic [12:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; din = d;
    @(negedge clk); cs_n = 1; wr_n = 1; din = '0;
    #1;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cal_done = 1; else if (which == 1) az_done = 1; else conv_done = 1;
    @(negedge clk); cal_done = 0; az_done = 0; conv_done = 0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    cur_req = "R1";
    check("R1", "rdy_n in reset", int'(rdy_n), 1);
    check("R1", "stby_n in reset", int'(stby_n), 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1;
    check("R1", "cfg after reset", int'(cfg_out), 0);
    check("R1", "stby_n after reset", int'(stby_n), 0);

    cur_req = "R2";
    wr(13'h012); check("R2", "low byte", int'(cfg_out), 'h012);
    wr(13'h034); check("R2", "low byte again", int'(cfg_out), 'h034);

    cur_req = "R3";
    wr(13'h0A5); check("R3", "low with pointer", int'(cfg_out), 'h0A5);
    wr(13'h011); check("R3", "upper field", int'(cfg_out), 'h11A5);
    check("R5", "go_cal pulse", int'(go_cal), 1);
    check("R8", "stby exit", int'(stby_n), 1);
    @(negedge clk); #1; check("R5", "go_cal single", int'(go_cal), 0);
    check("R5", "busy during cal", int'(rdy_n), 1);

    cur_req = "R10";
    wr(13'h0FF); check("R10", "busy write ignored", int'(cfg_out), 'h11A5);
    cur_req = "R12";
    pulse(1); check("R12", "wrong done ignored", int'(rdy_n), 1);
    cur_req = "R5";
    pulse(0); check("R5", "ready after cal_done", int'(rdy_n), 0);

    wr(13'h080); wr(13'h002);
    check("R5", "go_az pulse", int'(go_az), 1);
    check("R3", "upper replaced", int'(cfg_out), 'h0280);
    pulse(2); check("R12", "conv_done in zeroing ignored", int'(rdy_n), 1);
    pulse(1); check("R5", "ready after az_done", int'(rdy_n), 0);
    cur_req = "R3";
    wr(13'h033); check("R3", "pointer cleared", int'(cfg_out), 'h0233);

    cur_req = "R4";
    mode13 = 1;
    wr(13'h045A); check("R4", "wide load", int'(cfg_out), 'h045A);
    check("R6", "go_conv pulse", int'(go_conv), 1);
    cur_req = "R6";
    conv_result = 12'hABC;
    pulse(2); check("R6", "ready after conversion", int'(rdy_n), 0);
    cur_req = "R11";
    @(negedge clk); cs_n = 0; rd_n = 0; #1;
    check("R11", "read result", int'(dout), 'hABC);
    @(negedge clk); cs_n = 1; rd_n = 1; #1;
    check("R11", "bus idle", int'(dout), 0);

    cur_req = "R7";
    wr(13'h0500); check("R7", "standby stby_n", int'(stby_n), 0);
    check("R7", "standby rdy_n", int'(rdy_n), 1);
    cur_req = "R13";
    wr(13'h0612); check("R13", "code 6 keeps standby", int'(stby_n), 0);
    check("R13", "code 6 stores", int'(cfg_out), 'h0612);
    cur_req = "R9";
    wr(13'h0300); check("R9", "reset clears cfg", int'(cfg_out), 0);
    check("R8", "reset code ready", int'(rdy_n), 0);
    check("R8", "reset code awake", int'(stby_n), 1);

    cur_req = "R13";
    wr(13'h1077); check("R13", "code 0 stores", int'(cfg_out), 'h1077);
    check("R13", "code 0 still ready", int'(rdy_n), 0);

    cur_req = "R12";
    conv_result = 12'h123;
    pulse(2); check("R12", "idle done ignored", int'(rdy_n), 0);
    @(negedge clk); cs_n = 0; rd_n = 0; #1;
    check("R12", "result kept", int'(dout), 'hABC);
    @(negedge clk); cs_n = 1; rd_n = 1;
    repeat (2) @(negedge clk);
    done_run = 1;
  end

  initial begin
    int cyc = 0;
    while (!done_run && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule